// File: doc/BRIEF.md
# Indexed Block-Access Register Target for a Two-Wire Serial Bus

This block is a two-wire serial bus target (SMBus/I2C style) that lets a host reach a bank of sixteen 8-bit configuration registers. The design samples SCL and SDA from a fast system clock and passes each line through a two-flop synchronizer and a majority-free glitch filter. It recognizes START, repeated START and STOP. It pulls SDA low through an open-drain output enable, and only to acknowledge or to send a read bit.

Every transfer uses indexed block addressing. In a write, the host gives a starting register index and a byte count, then that many data bytes. In a read, the host first sets the index with a short write phase. It then issues a repeated START with the read address. The target answers with a byte count taken from a dedicated count register, followed by the register contents. It keeps sending bytes for as long as the host acknowledges them. The register bank is also presented as a flat parallel output, so the surrounding logic can use the settings directly.

Top module: `smb_blk_target`

## Requirements
- R1: After reset, register 8 (the read-count register) holds 0x07 and every other register holds 0x00.
- R2: The target pulls SDA low in the ninth clock of the address byte 0xD2 (write) and of the address byte 0xD3 (read), that is, 7-bit address 0x69 with R/W in bit 0.
- R3: Any other address byte gets no acknowledge. After it, SDA stays released and no register changes until the next START or STOP, whatever bytes follow.
- R4: A block write (address 0xD2, index N, count X, then X data bytes) acknowledges every byte. It stores the data bytes in registers N, N+1, … in ascending order. Register writes take effect only while SCL is low.
- R5: Data bytes that arrive after the X counted bytes of a write are not acknowledged and are not stored.
- R6: The register index wraps modulo 16, both on writes and on reads.
- R7: After a repeated START and 0xD3, the target sends the value of register 8 first. It then sends registers from index N upward, each byte MSB first.
- R8: While the host acknowledges, the target keeps sending the following registers, even past the count. After a host NACK it releases SDA and sends nothing more until the next START or STOP.
- R9: A value written to register 8 is the count byte returned by a later read.
- R10: A START or STOP aborts any transfer in progress, releases SDA, and restarts address matching. A byte cut short by a START is not stored.
- R11: The target changes its SDA drive only while SCL is low.
- R12: An SCL pulse shorter than the filter length (4 system clocks) is not taken as a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| regs_o | output | 128 | Register bank, register k in bits 8k+7:8k |

## Verification
The assertions rely on a well-formed bus. SDA moves only while SCL is low, except for deliberate START and STOP conditions. Each SCL level lasts well beyond the synchronizer and filter delay, so the target can react to a falling edge before SCL rises again. The bench host model keeps each quarter bit at 20 system clocks and never lets SDA move during an SCL high phase, other than for START and STOP. Its single glitch is a 2-clock SCL pulse placed inside a low phase.

// File: rtl/smb_blk_target.sv
module smb_blk_target #(
  parameter logic [6:0] ADDR7   = 7'h69,
  parameter int         NREG    = 16,
  parameter int         CNT_IDX = 8,
  parameter logic [7:0] CNT_RST = 8'h07,
  parameter int         FILT    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] regs_o
);
  localparam int AW = $clog2(NREG);
  localparam logic [AW-1:0] PTR_ONE = AW'(1);
  localparam logic [7:0] WR_ADDR = {ADDR7, 1'b0};
  localparam logic [7:0] RD_ADDR = {ADDR7, 1'b1};

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_HACK, ST_IGN} st_t;
  typedef enum logic [1:0] {PH_ADDR, PH_IDX, PH_CNT, PH_DATA} ph_t;

  logic [1:0]      scl_s, sda_s;
  logic [FILT-1:0] scl_h, sda_h;
  logic            scl_f, sda_f, scl_p, sda_p;
  logic            start_det, stop_det, scl_rise, scl_fall;

  st_t            st;
  ph_t            ph;
  logic [3:0]     bits;
  logic [7:0]     sh;
  logic [7:0]     left;
  logic [AW-1:0]  ptr;
  logic           rd;
  logic           hack;
  logic [7:0]     regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= 2'b11;
      sda_s <= 2'b11;
      scl_h <= '1;
      sda_h <= '1;
      scl_f <= 1'b1;
      sda_f <= 1'b1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_h <= {scl_h[FILT-2:0], scl_s[1]};
      sda_h <= {sda_h[FILT-2:0], sda_s[1]};
      if (&scl_h) scl_f <= 1'b1;
      else if (~|scl_h) scl_f <= 1'b0;
      if (&sda_h) sda_f <= 1'b1;
      else if (~|sda_h) sda_f <= 1'b0;
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign start_det = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_det  = scl_f & scl_p & ~sda_p & sda_f;
  assign scl_rise  = scl_f & ~scl_p;
  assign scl_fall  = ~scl_f & scl_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      ph     <= PH_ADDR;
      bits   <= '0;
      sh     <= '0;
      left   <= '0;
      ptr    <= '0;
      rd     <= 1'b0;
      hack   <= 1'b0;
      sda_oe <= 1'b0;
      for (int i = 0; i < NREG; i++)
        regs[i] <= (i == CNT_IDX) ? CNT_RST : 8'h00;
    end else if (start_det) begin
      st     <= ST_RX;
      ph     <= PH_ADDR;
      bits   <= '0;
      rd     <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      st     <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        ST_RX: begin
          if (scl_rise) begin
            sh   <= {sh[6:0], sda_f};
            bits <= bits + 4'd1;
          end else if (scl_fall && bits == 4'd8) begin
            bits <= '0;
            case (ph)
              PH_ADDR: begin
                if (sh == WR_ADDR) begin
                  sda_oe <= 1'b1;
                  st     <= ST_ACK;
                  ph     <= PH_IDX;
                end else if (sh == RD_ADDR) begin
                  sda_oe <= 1'b1;
                  st     <= ST_ACK;
                  rd     <= 1'b1;
                end else begin
                  st <= ST_IGN;
                end
              end
              PH_IDX: begin
                ptr    <= sh[AW-1:0];
                sda_oe <= 1'b1;
                st     <= ST_ACK;
                ph     <= PH_CNT;
              end
              PH_CNT: begin
                left   <= sh;
                sda_oe <= 1'b1;
                st     <= ST_ACK;
                ph     <= PH_DATA;
              end
              default: begin
                if (left != 8'd0) begin
                  regs[ptr] <= sh;
                  ptr       <= ptr + PTR_ONE;
                  left      <= left - 8'd1;
                  sda_oe    <= 1'b1;
                  st        <= ST_ACK;
                end else begin
                  st <= ST_IGN;
                end
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bits <= '0;
            if (rd) begin
              sh     <= regs[CNT_IDX];
              sda_oe <= ~regs[CNT_IDX][7];
              st     <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              st     <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bits == 4'd7) begin
              sda_oe <= 1'b0;
              st     <= ST_HACK;
            end else begin
              sh     <= {sh[6:0], 1'b0};
              sda_oe <= ~sh[6];
              bits   <= bits + 4'd1;
            end
          end
        end
        ST_HACK: begin
          if (scl_rise) begin
            hack <= ~sda_f;
          end else if (scl_fall) begin
            if (hack) begin
              sh     <= regs[ptr];
              sda_oe <= ~regs[ptr][7];
              ptr    <= ptr + PTR_ONE;
              bits   <= '0;
              st     <= ST_TX;
            end else begin
              st <= ST_IGN;
            end
          end
        end
        default: sda_oe <= 1'b0;
      endcase
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_o[g*8 +: 8] = regs[g];
  end
endmodule

module smb_blk_target_chk #(
  parameter int         NREG    = 16,
  parameter int         CNT_IDX = 8,
  parameter logic [7:0] CNT_RST = 8'h07
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_f,
  input logic              start_det,
  input logic              stop_det,
  input logic              sda_oe,
  input logic [NREG*8-1:0] regs_o
);
  a_r1_count_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> regs_o[CNT_IDX*8 +: 8] == CNT_RST);

  a_r11_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f);

  a_r11_release_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> (!scl_f || $past(start_det) || $past(stop_det)));

  a_r4_write_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_o) |-> !scl_f);

  a_r10_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  a_r10_start_release: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);
endmodule

bind smb_blk_target smb_blk_target_chk #(
  .NREG(NREG), .CNT_IDX(CNT_IDX), .CNT_RST(CNT_RST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .start_det(start_det),
  .stop_det(stop_det), .sda_oe(sda_oe), .regs_o(regs_o)
);

// File: tb/test_smb_blk_target.sv
`timescale 1ns/1ps
module test_smb_blk_target;
  localparam int Q = 200;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         host_scl = 1'b1;
  logic         host_sda = 1'b1;
  logic         sda_oe;
  logic [127:0] regs_o;
  wire          sda_line = host_sda & ~sda_oe;

  int checks = 0;
  int fails = 0;
  int viol = 0;
  logic oe_prev = 1'b0;
  logic [7:0] m [16];

  always #5 clk = ~clk;

  smb_blk_target i_smb_blk_target (
    .clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .regs_o(regs_o)
  );

  always @(negedge clk) begin
    if (rst_n && host_scl && sda_oe !== oe_prev) viol++;
    oe_prev <= sda_oe;
  end

  function automatic logic [7:0] reg_at(int i);
    return regs_o[i*8 +: 8];
  endfunction

  function automatic logic [7:0] pat(int i);
    return 8'((i * 29 + 3) & 255);
  endfunction

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", r, act, exp);
    end
  endtask

  task automatic bstart();
    host_sda = 1'b1; #Q host_scl = 1'b1; #Q host_sda = 1'b0; #Q host_scl = 1'b0; #Q;
  endtask

  task automatic bstop();
    host_sda = 1'b0; #Q host_scl = 1'b1; #Q host_sda = 1'b1; #Q;
  endtask

  task automatic wr_bit(logic b);
    host_sda = b; #Q host_scl = 1'b1; #(2*Q) host_scl = 1'b0; #Q;
  endtask

  task automatic wr_byte(logic [7:0] b, output logic ack, input logic glitch = 1'b0);
    for (int i = 7; i >= 0; i--) begin
      if (glitch && i == 3) begin
        host_sda = b[i]; #50 host_scl = 1'b1; #20 host_scl = 1'b0; #(Q-70);
        host_scl = 1'b1; #(2*Q) host_scl = 1'b0; #Q;
      end else begin
        wr_bit(b[i]);
      end
    end
    host_sda = 1'b1; #Q host_scl = 1'b1; #Q ack = ~sda_line; #Q host_scl = 1'b0; #Q;
  endtask

  task automatic rd_byte(output logic [7:0] d, input logic nack);
    host_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      #Q host_scl = 1'b1; #Q d[i] = sda_line; #Q host_scl = 1'b0; #Q;
    end
    host_sda = nack; #Q host_scl = 1'b1; #(2*Q) host_scl = 1'b0; #Q;
    host_sda = 1'b1;
  endtask

  task automatic wr_ack(string r, logic [7:0] b, logic exp);
    logic a;
    wr_byte(b, a);
    chk(r, int'(a), int'(exp));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] d;
    logic a;
    logic [127:0] snap;
    repeat (10) @(posedge clk);
    #2 rst_n = 1'b1;
    #100;

    for (int i = 0; i < 16; i++) begin
      m[i] = (i == 8) ? 8'h07 : 8'h00;
      chk("R1 reset value", int'(reg_at(i)), int'(m[i]));
    end

    // R2 R4 sweep write of all registers
    bstart();
    wr_ack("R2 write address ack", 8'hD2, 1'b1);
    wr_ack("R4 index ack", 8'h00, 1'b1);
    wr_ack("R4 count ack", 8'd16, 1'b1);
    for (int i = 0; i < 16; i++) begin
      wr_ack("R4 data ack", pat(i), 1'b1);
      m[i] = pat(i);
    end
    bstop();
    for (int i = 0; i < 16; i++) chk("R4 stored byte", int'(reg_at(i)), int'(m[i]));

    // R7 read back: count byte first, then registers from index 0
    bstart();
    wr_ack("R2 write address ack", 8'hD2, 1'b1);
    wr_ack("R7 index ack", 8'h00, 1'b1);
    bstart();
    wr_ack("R2 read address ack", 8'hD3, 1'b1);
    rd_byte(d, 1'b0);
    chk("R7 count byte", int'(d), int'(m[8]));
    for (int i = 0; i < 16; i++) begin
      rd_byte(d, i == 15);
      chk("R7 read data", int'(d), int'(m[i]));
    end
    bstop();

    // R6 wrap on write
    bstart();
    wr_ack("R2 write address ack", 8'hD2, 1'b1);
    wr_ack("R6 index ack", 8'd14, 1'b1);
    wr_ack("R6 count ack", 8'd4, 1'b1);
    for (int i = 0; i < 4; i++) begin
      wr_ack("R6 data ack", 8'hA0 + 8'(i), 1'b1);
      m[(14 + i) % 16] = 8'hA0 + 8'(i);
    end
    bstop();
    for (int i = 0; i < 16; i++) chk("R6 wrapped write", int'(reg_at(i)), int'(m[i]));

    // R5 bytes beyond count
    bstart();
    wr_ack("R2 write address ack", 8'hD2, 1'b1);
    wr_ack("R5 index ack", 8'd10, 1'b1);
    wr_ack("R5 count ack", 8'd1, 1'b1);
    wr_ack("R5 counted byte ack", 8'h11, 1'b1);
    m[10] = 8'h11;
    wr_ack("R5 extra byte nack", 8'h22, 1'b0);
    bstop();
    chk("R5 counted byte stored", int'(reg_at(10)), int'(m[10]));
    chk("R5 extra byte not stored", int'(reg_at(11)), int'(m[11]));

    // R3 foreign address
    snap = regs_o;
    bstart();
    wr_ack("R3 foreign address nack", 8'hA4, 1'b0);
    wr_ack("R3 later byte nack", 8'h00, 1'b0);
    wr_ack("R3 later byte nack", 8'h55, 1'b0);
    bstop();
    chk("R3 registers untouched", int'(regs_o == snap), 1);

    // R9 set the read count, R8 continue past it and stop on NACK
    bstart();
    wr_ack("R2 write address ack", 8'hD2, 1'b1);
    wr_ack("R9 index ack", 8'd8, 1'b1);
    wr_ack("R9 count ack", 8'd1, 1'b1);
    wr_ack("R9 data ack", 8'd2, 1'b1);
    m[8] = 8'd2;
    bstop();
    bstart();
    wr_ack("R2 write address ack", 8'hD2, 1'b1);
    wr_ack("R8 index ack", 8'd14, 1'b1);
    bstart();
    wr_ack("R2 read address ack", 8'hD3, 1'b1);
    rd_byte(d, 1'b0);
    chk("R9 count byte", int'(d), 2);
    rd_byte(d, 1'b0);
    chk("R7 read data", int'(d), int'(m[14]));
    rd_byte(d, 1'b0);
    chk("R6 read data", int'(d), int'(m[15]));
    rd_byte(d, 1'b1);
    chk("R8 read past count wraps", int'(d), int'(m[0]));
    rd_byte(d, 1'b1);
    chk("R8 released after NACK", int'(d), 8'hFF);
    bstop();

    // R10 stop and start abort
    bstart();
    wr_ack("R2 write address ack", 8'hD2, 1'b1);
    wr_ack("R10 index ack", 8'd5, 1'b1);
    wr_ack("R10 count ack", 8'd3, 1'b1);
    wr_ack("R10 data ack", 8'h77, 1'b1);
    m[5] = 8'h77;
    bstop();
    chk("R10 released after stop", int'(sda_oe), 0);
    bstart();
    wr_ack("R2 write address ack", 8'hD2, 1'b1);
    wr_ack("R10 index ack", 8'd6, 1'b1);
    wr_ack("R10 count ack", 8'd2, 1'b1);
    for (int i = 0; i < 4; i++) wr_bit(1'b1);
    bstart();
    wr_ack("R10 address after abort", 8'hD2, 1'b1);
    wr_ack("R10 index ack", 8'd7, 1'b1);
    wr_ack("R10 count ack", 8'd1, 1'b1);
    wr_ack("R10 data ack", 8'h99, 1'b1);
    m[7] = 8'h99;
    bstop();
    chk("R10 first byte kept", int'(reg_at(5)), int'(m[5]));
    chk("R10 cut byte not stored", int'(reg_at(6)), int'(m[6]));
    chk("R10 new transfer stored", int'(reg_at(7)), int'(m[7]));

    // R12 glitch on SCL inside a data byte
    bstart();
    wr_ack("R2 write address ack", 8'hD2, 1'b1);
    wr_ack("R12 index ack", 8'd9, 1'b1);
    wr_ack("R12 count ack", 8'd1, 1'b1);
    wr_byte(8'h3C, a, 1'b1);
    chk("R12 glitched byte ack", int'(a), 1);
    m[9] = 8'h3C;
    bstop();
    chk("R12 glitched byte stored", int'(reg_at(9)), int'(m[9]));

    chk("R11 drive changes with SCL high", viol, 0);
    summary();
  end
endmodule